// File: doc/BRIEF.md
# Multi-core boot release table

This block is a small memory-mapped table that parks the secondary processor cores of a multi-core cluster until boot software hands each of them a start address. Every core owns one 32-byte slot. A slot holds a 64-bit start address, a 64-bit argument and a 32-bit core identifier. The remaining bytes of the slot are reserved. Software reaches the table over a simple register-bus slave port that takes byte, halfword and word accesses with big-endian byte lanes.

Software releases a core by writing that core's slot so that bit 0 of the start address becomes 0. One cycle later the table raises a single-cycle pulse on the release line for that core. With the pulse it presents the start offset inside a 64 MiB mapping window, the window-aligned mapping base and the argument value. In the cycle of the pulse, the table also overwrites the slot's core identifier with the core's hardware ID. Loading processor registers, programming the MMU and waking the core are the job of the logic that consumes the pulse.

Top module: `core_boot_table`

## Requirements
- R1: After reset, slot i of every present core holds start address 1, argument i and core identifier i.
- R2: Slot index is address bits [9:5] and the byte offset within the slot is address bits [4:0]. A read returns the addressed bytes in the same cycle, right-justified on the 32-bit bus with zero fill. The lowest address is the most significant byte. Bytes past the end of the slot read as zero. Size code 0 means byte, 1 means halfword, 2 means word, and 3 reads as zero.
- R3: Slot byte layout: offsets 0..7 hold the start address (most significant byte first), 8..15 hold the argument, 20..23 hold the core identifier. A write of any legal size updates exactly the addressed bytes using the same big-endian lane mapping. A write with size code 3 changes nothing.
- R4: Writes to slot 0 are dropped, and core 0 never receives a release pulse.
- R5: Slots at or above NUM_CORES read as zero, ignore writes and never produce a release.
- R6: Reserved offsets 16..19 and 24..31 read as zero and keep no written data.
- R7: An accepted write that leaves bit 0 of the slot's start address at 0 raises that core's release bit for exactly the one cycle after the write. Any write that leaves bit 0 at 1 raises no release.
- R8: While bit 0 stays clear, every further accepted write to the slot raises a fresh pulse.
- R9: With a pulse, the start offset output equals the start address modulo 2^26, the base output equals the start address with bits [25:0] cleared, and the argument output equals the slot's argument after the write. The window size output is 64 MiB.
- R10: In the pulse cycle, the slot's core identifier is loaded from that core's hardware ID. A bus write to the identifier in the same cycle loses to this load.
- R11: The release vector is one-hot or zero, and the core index output names the pulsing bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access valid |
| we_i | input | 1 | Write enable |
| addr_i | input | 10 | Byte address into the table |
| size_i | input | 2 | Access size code (0 byte, 1 half, 2 word) |
| wdata_i | input | 32 | Write data, right-justified |
| rdata_o | output | 32 | Read data, right-justified, combinational |
| hwid_i | input | NUM_CORES*32 | Hardware ID per core, core g at bits [32g+31:32g] |
| rel_o | output | NUM_CORES | Per-core release pulse |
| rel_core_o | output | 5 | Index of the released core |
| rel_pc_o | output | 64 | Start offset inside the mapping window |
| rel_base_o | output | 64 | Window-aligned mapping base |
| rel_arg_o | output | 64 | Argument handed to the core |
| win_size_o | output | 64 | Mapping window size in bytes |

## Verification
The identifier load of a release and a bus write to the same identifier bytes can fall in the same cycle. The bench provokes this by releasing a core and then writing its identifier word in the very cycle the pulse is out. It judges the result with a read in the next cycle, before the second pulse lands, which must return the hardware ID and not the written value. Release timing and payload splitting are checked on a slot whose address is assembled from two word writes with upper bits set.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  localparam int SLOT_BYTES = 32;
  localparam int SLOT_BITS  = SLOT_BYTES * 8;
  localparam int WIN_BITS   = 26;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_NONE = 2'd3
  } acc_size_e;

  function automatic int size_bytes(logic [1:0] s);
    case (s)
      SZ_BYTE: return 1;
      SZ_HALF: return 2;
      SZ_WORD: return 4;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/cbt_decode.sv
module cbt_decode import cbt_pkg::*; #(
  parameter int NUM_ENTRIES = 32,
  parameter int NUM_CORES   = 4,
  localparam int IDXW = $clog2(NUM_ENTRIES),
  localparam int AW   = IDXW + 5
) (
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [1:0]           size_i,
  input  logic [31:0]          wdata_i,
  output logic [IDXW-1:0]      idx_o,
  output logic [4:0]           off_o,
  output logic                 wr_ok_o,
  output logic [SLOT_BYTES-1:0] be_o,
  output logic [SLOT_BITS-1:0] wimg_o
);
  assign idx_o = addr_i[AW-1:5];
  assign off_o = addr_i[4:0];

  assign wr_ok_o = req_i && we_i && (size_i != SZ_NONE) &&
                   (idx_o != '0) && (int'(idx_o) < NUM_CORES);

  // place right-justified write bytes onto the big-endian slot image
  always_comb begin
    int n;
    int p;
    n = size_bytes(size_i);
    be_o = '0;
    wimg_o = '0;
    for (int k = 0; k < 4; k++) begin
      p = int'(off_o) + k;
      if (k < n && p < SLOT_BYTES) begin
        be_o[p] = 1'b1;
        wimg_o[SLOT_BITS-1-8*p -: 8] = wdata_i[8*(n-1-k) +: 8];
      end
    end
  end
endmodule

// File: rtl/cbt_slot.sv
module cbt_slot import cbt_pkg::*; #(
  parameter int INDEX = 0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [SLOT_BYTES-1:0] be_i,
  input  logic [SLOT_BITS-1:0]  wimg_i,
  input  logic                  id_ld_i,
  input  logic [31:0]           id_val_i,
  output logic [SLOT_BITS-1:0]  img_o,
  output logic [63:0]           nxt_addr_o,
  output logic [63:0]           nxt_arg_o
);
  logic [63:0] addr_q, arg_q;
  logic [31:0] id_q;
  logic [SLOT_BITS-1:0] merged;
  logic [31:0] nxt_id;

  // reserved words are not stored
  assign img_o = {addr_q, arg_q, 32'h0, id_q, 64'h0};

  always_comb begin
    for (int o = 0; o < SLOT_BYTES; o++)
      merged[SLOT_BITS-1-8*o -: 8] = be_i[o] ? wimg_i[SLOT_BITS-1-8*o -: 8]
                                             : img_o[SLOT_BITS-1-8*o -: 8];
  end

  assign nxt_addr_o = merged[255:192];
  assign nxt_arg_o  = merged[191:128];
  assign nxt_id     = merged[95:64];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= 64'd1;
      arg_q  <= 64'(INDEX);
      id_q   <= 32'(INDEX);
    end else begin
      if (wr_en_i) begin
        addr_q <= nxt_addr_o;
        arg_q  <= nxt_arg_o;
        id_q   <= nxt_id;
      end
      if (id_ld_i) id_q <= id_val_i;  // release load wins over bus
    end
  end
endmodule

// File: rtl/cbt_read.sv
module cbt_read import cbt_pkg::*; #(
  parameter int NUM_ENTRIES = 32,
  parameter int NUM_CORES   = 4,
  localparam int IDXW = $clog2(NUM_ENTRIES)
) (
  input  logic [NUM_CORES*SLOT_BITS-1:0] imgs_i,
  input  logic [IDXW-1:0]                idx_i,
  input  logic [4:0]                     off_i,
  input  logic [1:0]                     size_i,
  output logic [31:0]                    rdata_o
);
  logic [SLOT_BITS-1:0] sel;

  always_comb begin
    sel = '0;
    for (int g = 0; g < NUM_CORES; g++)
      if (int'(idx_i) == g) sel = imgs_i[g*SLOT_BITS +: SLOT_BITS];
  end

  always_comb begin
    int n;
    int p;
    n = size_bytes(size_i);
    rdata_o = '0;
    for (int k = 0; k < 4; k++) begin
      p = int'(off_i) + k;
      if (k < n) begin
        rdata_o = rdata_o << 8;
        if (p < SLOT_BYTES) rdata_o[7:0] = sel[SLOT_BITS-1-8*p -: 8];
      end
    end
  end
endmodule

// File: rtl/cbt_release.sv
module cbt_release import cbt_pkg::*; #(
  parameter int NUM_ENTRIES = 32,
  parameter int NUM_CORES   = 4,
  localparam int IDXW = $clog2(NUM_ENTRIES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_ok_i,
  input  logic [IDXW-1:0]      idx_i,
  input  logic [63:0]          nxt_addr_i,
  input  logic [63:0]          nxt_arg_i,
  output logic [NUM_CORES-1:0] rel_o,
  output logic [IDXW-1:0]      rel_core_o,
  output logic [63:0]          rel_pc_o,
  output logic [63:0]          rel_base_o,
  output logic [63:0]          rel_arg_o
);
  localparam logic [63:0] WIN_MASK = (64'd1 << WIN_BITS) - 64'd1;

  logic fire, v_q;
  assign fire = wr_ok_i && !nxt_addr_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q        <= 1'b0;
      rel_core_o <= '0;
      rel_pc_o   <= '0;
      rel_base_o <= '0;
      rel_arg_o  <= '0;
    end else begin
      v_q <= fire;
      if (fire) begin
        rel_core_o <= idx_i;
        rel_pc_o   <= nxt_addr_i & WIN_MASK;
        rel_base_o <= nxt_addr_i & ~WIN_MASK;
        rel_arg_o  <= nxt_arg_i;
      end
    end
  end

  always_comb begin
    rel_o = '0;
    for (int g = 0; g < NUM_CORES; g++)
      if (v_q && int'(rel_core_o) == g) rel_o[g] = 1'b1;
  end
endmodule

// File: rtl/core_boot_table.sv
module core_boot_table import cbt_pkg::*; #(
  parameter int NUM_ENTRIES = 32,
  parameter int NUM_CORES   = 4,
  localparam int IDXW = $clog2(NUM_ENTRIES),
  localparam int AW   = IDXW + 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [1:0]              size_i,
  input  logic [31:0]             wdata_i,
  output logic [31:0]             rdata_o,
  input  logic [NUM_CORES*32-1:0] hwid_i,
  output logic [NUM_CORES-1:0]    rel_o,
  output logic [IDXW-1:0]         rel_core_o,
  output logic [63:0]             rel_pc_o,
  output logic [63:0]             rel_base_o,
  output logic [63:0]             rel_arg_o,
  output logic [63:0]             win_size_o
);
  logic [IDXW-1:0]              idx;
  logic [4:0]                   off;
  logic                         wr_ok;
  logic [SLOT_BYTES-1:0]        be;
  logic [SLOT_BITS-1:0]         wimg;
  logic [NUM_CORES*SLOT_BITS-1:0] imgs;
  logic [NUM_CORES*64-1:0]      nxt_addrs, nxt_args;
  logic [63:0]                  nxt_addr, nxt_arg;

  assign win_size_o = 64'd1 << WIN_BITS;

  cbt_decode #(.NUM_ENTRIES(NUM_ENTRIES), .NUM_CORES(NUM_CORES)) u_dec (
    .req_i, .we_i, .addr_i, .size_i, .wdata_i,
    .idx_o(idx), .off_o(off), .wr_ok_o(wr_ok), .be_o(be), .wimg_o(wimg)
  );

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_slot
    cbt_slot #(.INDEX(g)) u_slot (
      .clk_i, .rst_ni,
      .wr_en_i(wr_ok && int'(idx) == g),
      .be_i(be), .wimg_i(wimg),
      .id_ld_i(rel_o[g]), .id_val_i(hwid_i[g*32 +: 32]),
      .img_o(imgs[g*SLOT_BITS +: SLOT_BITS]),
      .nxt_addr_o(nxt_addrs[g*64 +: 64]),
      .nxt_arg_o(nxt_args[g*64 +: 64])
    );
  end

  always_comb begin
    nxt_addr = 64'd1;
    nxt_arg  = '0;
    for (int g = 0; g < NUM_CORES; g++)
      if (int'(idx) == g) begin
        nxt_addr = nxt_addrs[g*64 +: 64];
        nxt_arg  = nxt_args[g*64 +: 64];
      end
  end

  cbt_read #(.NUM_ENTRIES(NUM_ENTRIES), .NUM_CORES(NUM_CORES)) u_rd (
    .imgs_i(imgs), .idx_i(idx), .off_i(off), .size_i, .rdata_o
  );

  cbt_release #(.NUM_ENTRIES(NUM_ENTRIES), .NUM_CORES(NUM_CORES)) u_rel (
    .clk_i, .rst_ni, .wr_ok_i(wr_ok), .idx_i(idx),
    .nxt_addr_i(nxt_addr), .nxt_arg_i(nxt_arg),
    .rel_o, .rel_core_o, .rel_pc_o, .rel_base_o, .rel_arg_o
  );
endmodule

// File: rtl/cbt_chk.sv
module cbt_chk #(
  parameter int NUM_ENTRIES = 32,
  parameter int NUM_CORES   = 4,
  localparam int IDXW = $clog2(NUM_ENTRIES),
  localparam int AW   = IDXW + 5
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_i,
  input logic                 we_i,
  input logic [AW-1:0]        addr_i,
  input logic [1:0]           size_i,
  input logic [NUM_CORES-1:0] rel_o,
  input logic [IDXW-1:0]      rel_core_o
);
  // R11
  rel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rel_o));

  // R4
  no_core0_rel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rel_o[0]);

  // R7
  rel_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rel_o) |-> $past(req_i && we_i && size_i != 2'd3));

  // R11
  rel_core_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rel_o) |-> (rel_core_o == $past(addr_i[AW-1:5])));

  // R5
  absent_no_rel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && int'(addr_i[AW-1:5]) >= NUM_CORES) |=> (rel_o == '0));
endmodule

bind core_boot_table cbt_chk #(.NUM_ENTRIES(NUM_ENTRIES), .NUM_CORES(NUM_CORES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
  .addr_i(addr_i), .size_i(size_i), .rel_o(rel_o), .rel_core_o(rel_core_o)
);

// File: tb/core_boot_table_tb.sv
`timescale 1ns/1ps
module core_boot_table_tb_top;
  localparam int NE = 32;
  localparam int NC = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [9:0] addr = '0;
  logic [1:0] size = 2'd2;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NC*32-1:0] hwid;
  logic [NC-1:0] rel;
  logic [4:0] rel_core;
  logic [63:0] rel_pc, rel_base, rel_arg, win_size;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  for (genvar g = 0; g < NC; g++) begin : g_id
    assign hwid[g*32 +: 32] = 32'hA0 + g;
  end

  core_boot_table #(.NUM_ENTRIES(NE), .NUM_CORES(NC)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .rdata_o(rdata), .hwid_i(hwid),
    .rel_o(rel), .rel_core_o(rel_core), .rel_pc_o(rel_pc),
    .rel_base_o(rel_base), .rel_arg_o(rel_arg), .win_size_o(win_size)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // called just after a negedge; drives one write through the next posedge
  task automatic wr(int a, int s, logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = 10'(a); size = 2'(s); wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(string tag, int a, int s, logic [31:0] exp);
    addr = 10'(a); size = 2'(s);
    #1;
    chk(tag, {32'h0, rdata}, {32'h0, exp});
  endtask

  function automatic logic [31:0] reset_word(int e, int w);
    if (e >= NC) return 32'h0;
    case (w)
      1: return 32'h1;
      3: return 32'(e);
      5: return 32'(e);
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [7:0] reset_byte(int e, int o);
    logic [31:0] w;
    w = reset_word(e, o / 4);
    return w[8*(3 - o % 4) +: 8];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    chk("R1 reset rel idle", {60'h0, rel}, 64'h0);
    chk("R9 window size", win_size, 64'h400_0000);

    // R1 R5 R6: full word sweep of reset contents
    for (int e = 0; e < NE; e++)
      for (int w = 0; w < 8; w++)
        rd("R1 reset word", e*32 + w*4, 2, reset_word(e, w));

    // R2: byte and halfword sweep of one slot
    for (int o = 0; o < 32; o++)
      rd("R2 byte read", 3*32 + o, 0, {24'h0, reset_byte(3, o)});
    for (int o = 0; o < 32; o += 2)
      rd("R2 half read", 3*32 + o, 1,
         {16'h0, reset_byte(3, o), reset_byte(3, o + 1)});
    rd("R2 word past slot end", 1*32 + 30, 2, 32'h0);
    rd("R2 size3 read", 1*32 + 4, 3, 32'h0);

    // R4: slot 0 ignores writes
    wr(4, 2, 32'h0);
    chk("R4 no release core0", {60'h0, rel}, 64'h0);
    rd("R4 slot0 unchanged", 4, 2, 32'h1);

    // R5: absent slot
    wr(5*32 + 8, 2, 32'h1234);
    chk("R5 no release absent", {60'h0, rel}, 64'h0);
    rd("R5 absent reads zero", 5*32 + 8, 2, 32'h0);

    // R3: size 3 write changes nothing
    wr(1*32 + 12, 3, 32'hDEAD);
    chk("R3 size3 no release", {60'h0, rel}, 64'h0);
    rd("R3 size3 no write", 1*32 + 12, 2, 32'h1);

    // R7: bit0 left set -> no release
    wr(1*32 + 4, 2, 32'h3);
    chk("R7 bit0 set no release", {60'h0, rel}, 64'h0);
    rd("R3 addr low word", 1*32 + 4, 2, 32'h3);

    // R7 R9: assemble start address in slot 2
    wr(2*32 + 0, 2, 32'h12);
    chk("R7 high word no release", {60'h0, rel}, 64'h0);
    wr(2*32 + 4, 2, 32'h0C00_0124);
    chk("R7 release pulse", {60'h0, rel}, 64'h4);
    chk("R11 release core", {59'h0, rel_core}, 64'd2);
    chk("R9 start offset", rel_pc, 64'h124);
    chk("R9 base", rel_base, 64'h12_0C00_0000);
    chk("R9 arg", rel_arg, 64'd2);
    @(negedge clk);
    chk("R7 pulse one cycle", {60'h0, rel}, 64'h0);
    rd("R10 id loaded", 2*32 + 20, 2, 32'hA2);

    // R8 R3: fresh pulse on arg byte write
    wr(2*32 + 15, 0, 32'h77);
    chk("R8 fresh pulse", {60'h0, rel}, 64'h4);
    chk("R9 arg after byte write", rel_arg, 64'h77);
    wr(2*32 + 8, 1, 32'hBEEF);
    chk("R8 pulse on half write", {60'h0, rel}, 64'h4);
    chk("R9 arg after half write", rel_arg, 64'hBEEF_0000_0000_0077);
    rd("R3 arg high word", 2*32 + 8, 2, 32'hBEEF_0000);
    rd("R3 arg low byte", 2*32 + 15, 0, 32'h77);
    rd("R3 arg low half", 2*32 + 14, 1, 32'h77);

    // R6: reserved bytes keep nothing
    wr(2*32 + 16, 2, 32'hFFFF_FFFF);
    rd("R6 reserved word", 2*32 + 16, 2, 32'h0);
    wr(2*32 + 28, 2, 32'hFFFF_FFFF);
    rd("R6 reserved tail", 2*32 + 28, 2, 32'h0);

    // R10: id write in the pulse cycle loses to the hardware id load
    wr(3*32 + 4, 2, 32'h0);
    chk("R7 release core3", {60'h0, rel}, 64'h8);
    chk("R9 base zero", rel_base, 64'h0);
    wr(3*32 + 20, 2, 32'h55);
    rd("R10 id load wins", 3*32 + 20, 2, 32'hA3);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule